// File: doc/BRIEF.md
# Two-Channel Wiper Register Slave on a Two-Wire Bus

This block is a two-wire (I2C-compatible) slave that holds two 8-bit wiper position codes and one shutdown flag. It oversamples SCL and SDA with a faster system clock and recognises START and STOP conditions. It shifts bytes in and out and pulls SDA low through an open-drain enable to acknowledge bytes and to send read data.

A write transfer carries an address byte, then an instruction byte, then any number of data bytes. The instruction picks the channel and sets or clears shutdown. Every data byte that follows lands in the selected channel. A read transfer returns the stored code of the channel picked by the last instruction, and repeats it until the master answers with a NACK.

While shutdown is set, both effective outputs read zero-scale, but the stored codes are kept. They reappear as soon as shutdown is cleared.

Top module: `dual_wiper_i2c`

## Requirements
- R1: After reset both stored codes are 0x80, shutdown is clear, channel 1 is selected and `sda_pull` is 0.
- R2: The 7-bit address is {ADDR_HI (default 5'b01011), `addr_pin`[1:0]}, sent MSB first and followed by the R/W bit (1 = read). On a match the slave pulls SDA low for the ninth pulse. On a mismatch it never pulls SDA and ignores every byte until the next START.
- R3: In a write, the byte after the address is the instruction. Bit 7 selects the channel (0 = channel 1, 1 = channel 2), bit 6 is the shutdown flag, and bits 5:0 have no effect. The slave acknowledges it.
- R4: Every data byte after the instruction, up to STOP or a repeated START, is acknowledged and replaces the stored code of the selected channel. The last byte wins.
- R5: While shutdown is set, `wiper_a` and `wiper_b` are 0 and `shdn_a`/`shdn_b` are 1. Data bytes still update the stored codes. Clearing shutdown shows the stored codes again at once.
- R6: A read sends the stored code of the selected channel, MSB first, starting right after the address acknowledge. Shutdown does not affect what is sent. Each master ACK makes the slave send the same code again.
- R7: A write that carries only an instruction byte changes the channel used by later reads.
- R8: A master NACK on the ninth pulse of a read makes the slave release SDA and stay silent until the next START.
- R9: A START at any point, including part-way through a byte, restarts address reception. A STOP returns the slave to idle with SDA released.
- R10: SDA is sampled on SCL rising edges, and `sda_pull` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| addr_pin | input | 2 | Low two address bits |
| sda_pull | output | 1 | 1 = drive SDA low, 0 = release |
| wiper_a | output | 8 | Effective code of channel 1 |
| wiper_b | output | 8 | Effective code of channel 2 |
| shdn_a | output | 1 | Shutdown indication for channel 1 |
| shdn_b | output | 1 | Shutdown indication for channel 2 |

## Verification
On every cycle the assertions check several properties. SDA may change only while SCL is low, and a STOP always leaves the slave idle with SDA released. A START always restarts reception. The stored codes move only on an accepted data byte, writes never happen during a read, and shutdown always forces both outputs to zero.

Other behaviours can only be shown by the bench's bus transfers. These are address matching against the pins, decoding of the instruction bits, streaming writes with the last byte winning, and readback following the last instruction-only write. Recovery after NACKs and after aborted partial bytes is shown the same way, by comparing the data read back with the bench's own register model.

// File: rtl/dwp_pkg.sv
package dwp_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RX   = 3'd1,
    S_ACK  = 3'd2,
    S_TX   = 3'd3,
    S_RACK = 3'd4
  } dwp_state_e;

  typedef enum logic [1:0] {
    K_ADDR  = 2'd0,
    K_INSTR = 2'd1,
    K_DATA  = 2'd2
  } dwp_kind_e;

  // address byte = {7-bit address, r/w}
  function automatic logic dwp_addr_hit(input logic [7:0] rx, input logic [6:0] own);
    return rx[7:1] == own;
  endfunction

  // shutdown forces zero-scale without touching the stored code
  function automatic logic [7:0] dwp_effective(input logic [7:0] stored, input logic off);
    return off ? 8'h00 : stored;
  endfunction
endpackage

// File: rtl/dwp_line_watch.sv
module dwp_line_watch #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/dwp_frame_engine.sv
module dwp_frame_engine
  import dwp_pkg::*;
#(
  parameter int              HI_W    = 5,
  parameter int              PIN_W   = 2,
  parameter logic [HI_W-1:0] ADDR_HI = 5'b01011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic [PIN_W-1:0] addr_pin,
  input  logic [7:0]       rd_byte,
  output logic             sda_pull,
  output logic             ev_addr_hit,
  output logic             ev_instr,
  output logic             ev_wr,
  output logic [7:0]       byte_out,
  output logic             is_read,
  output dwp_state_e       state
);
  localparam int ADDR_W = HI_W + PIN_W;
  localparam int CNT_W  = 4;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(8);

  dwp_kind_e        kind;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       shreg;
  logic             nack;
  logic             byte_done;
  logic [ADDR_W-1:0] own_addr;

  assign own_addr    = {ADDR_HI, addr_pin};
  assign byte_done   = (state == S_RX) && scl_fall && (cnt == LAST_BIT);
  assign ev_addr_hit = byte_done && (kind == K_ADDR) && dwp_addr_hit(shreg, own_addr);
  assign ev_instr    = byte_done && (kind == K_INSTR);
  assign ev_wr       = byte_done && (kind == K_DATA);
  assign byte_out    = shreg;
  assign sda_pull    = (state == S_ACK) || ((state == S_TX) && !shreg[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      kind    <= K_ADDR;
      cnt     <= '0;
      shreg   <= '0;
      nack    <= 1'b0;
      is_read <= 1'b0;
    end else if (bus_start) begin
      state   <= S_RX;
      kind    <= K_ADDR;
      cnt     <= '0;
      is_read <= 1'b0;
    end else if (bus_stop) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        S_RX: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (byte_done) begin
            unique case (kind)
              K_ADDR: begin
                if (ev_addr_hit) begin
                  state   <= S_ACK;
                  is_read <= shreg[0];
                  kind    <= K_INSTR;
                end else begin
                  state <= S_IDLE;
                end
              end
              K_INSTR: begin
                state <= S_ACK;
                kind  <= K_DATA;
              end
              default: state <= S_ACK;
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (is_read) begin
              state <= S_TX;
              shreg <= rd_byte;
            end else begin
              state <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == LAST_BIT) state <= S_RACK;
            else shreg <= {shreg[6:0], 1'b1};
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            nack <= sda_s;
          end else if (scl_fall) begin
            if (nack) begin
              state <= S_IDLE;
            end else begin
              state <= S_TX;
              shreg <= rd_byte;
              cnt   <= '0;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dwp_wiper_bank.sv
module dwp_wiper_bank
  import dwp_pkg::*;
#(
  parameter int         W   = 8,
  parameter int         CH  = 2,
  parameter logic [W-1:0] MID = 8'h80
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_instr,
  input  logic                 ev_wr,
  input  logic [7:0]           byte_in,
  output logic [CH-1:0][W-1:0] stored,
  output logic [CH-1:0][W-1:0] eff,
  output logic                 shdn,
  output logic [7:0]           rd_byte
);
  localparam int SEL_W = $clog2(CH);

  logic [SEL_W-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= '0;
      shdn <= 1'b0;
    end else if (ev_instr) begin
      sel  <= byte_in[7 -: SEL_W];
      shdn <= byte_in[6];
    end
  end

  for (genvar c = 0; c < CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stored[c] <= MID;
      else if (ev_wr && (sel == SEL_W'(c))) stored[c] <= byte_in[W-1:0];
    end
    assign eff[c] = dwp_effective(stored[c], shdn);
  end

  assign rd_byte = stored[sel];
endmodule

// File: rtl/dual_wiper_i2c.sv
module dual_wiper_i2c #(
  parameter logic [4:0] ADDR_HI = 5'b01011,
  parameter int         SYNC    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] addr_pin,
  output logic       sda_pull,
  output logic [7:0] wiper_a,
  output logic [7:0] wiper_b,
  output logic       shdn_a,
  output logic       shdn_b
);
  import dwp_pkg::*;

  logic scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;
  logic ev_addr_hit, ev_instr, ev_wr, is_read, shdn;
  logic [7:0] byte_bus, rd_byte;
  logic [1:0][7:0] stored, eff;
  dwp_state_e state;

  dwp_line_watch #(.STAGES(SYNC)) u_watch (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(ev_start), .bus_stop(ev_stop)
  );

  dwp_frame_engine #(.HI_W(5), .PIN_W(2), .ADDR_HI(ADDR_HI)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .bus_start(ev_start), .bus_stop(ev_stop),
    .addr_pin(addr_pin), .rd_byte(rd_byte), .sda_pull(sda_pull),
    .ev_addr_hit(ev_addr_hit), .ev_instr(ev_instr), .ev_wr(ev_wr),
    .byte_out(byte_bus), .is_read(is_read), .state(state)
  );

  dwp_wiper_bank #(.W(8), .CH(2), .MID(8'h80)) u_bank (
    .clk(clk), .rst_n(rst_n), .ev_instr(ev_instr), .ev_wr(ev_wr),
    .byte_in(byte_bus), .stored(stored), .eff(eff), .shdn(shdn),
    .rd_byte(rd_byte)
  );

  assign wiper_a = eff[0];
  assign wiper_b = eff[1];
  assign shdn_a  = shdn;
  assign shdn_b  = shdn;
endmodule

// File: rtl/dwp_chk.sv
module dwp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_pull,
  input logic [2:0] state,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       ev_wr,
  input logic       is_read,
  input logic [7:0] st0,
  input logic [7:0] st1,
  input logic       shdn_a,
  input logic [7:0] wiper_a,
  input logic [7:0] wiper_b
);
  // R10
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl_s);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (state == 3'd0 && !sda_pull));

  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (state == 3'd1));

  // R5
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_wr |=> ($stable(st0) && $stable(st1)));

  // R4
  write_not_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |-> !is_read);

  // R5
  shdn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_a |-> (wiper_a == 8'h00 && wiper_b == 8'h00));
endmodule

bind dual_wiper_i2c dwp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull(sda_pull),
  .state(state), .ev_start(ev_start), .ev_stop(ev_stop), .ev_wr(ev_wr),
  .is_read(is_read), .st0(stored[0]), .st1(stored[1]), .shdn_a(shdn_a),
  .wiper_a(wiper_a), .wiper_b(wiper_b)
);

// File: tb/sim_dual_wiper_i2c.sv
`timescale 1ns/1ps
module sim_dual_wiper_i2c;
  localparam int H = 8;
  localparam logic [4:0] HI = 5'b01011;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic [1:0] pins = 2'b00;
  logic sda_pull, shdn_a, shdn_b;
  logic [7:0] wiper_a, wiper_b;
  wire sda_line = m_sda & ~sda_pull;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_reg [2];
  logic m_sel = 1'b0, m_shdn = 1'b0;

  always #2.5 clk = ~clk;

  dual_wiper_i2c u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .addr_pin(pins), .sda_pull(sda_pull), .wiper_a(wiper_a),
    .wiper_b(wiper_b), .shdn_a(shdn_a), .shdn_b(shdn_b)
  );

  function automatic logic [7:0] exp_out(input logic [7:0] v, input logic off);
    if (off) return 8'h00;
    return v;
  endfunction

  function automatic logic [6:0] own_addr(input logic [1:0] p);
    return {HI, p};
  endfunction

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic chk_outs(input string req);
    chk(req, "wiper_a", wiper_a, exp_out(m_reg[0], m_shdn));
    chk(req, "wiper_b", wiper_b, exp_out(m_reg[1], m_shdn));
    chk(req, "shdn_a", shdn_a, m_shdn);
    chk(req, "shdn_b", shdn_b, m_shdn);
    chk(req, "sda released", sda_pull, 1'b0);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(H);
    scl = 1'b1; wt(H);
    m_sda = 1'b0; wt(H);
    scl = 1'b0; wt(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(H);
    scl = 1'b1; wt(H);
    m_sda = 1'b1; wt(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      m_sda = b[7-i]; wt(H);
      scl = 1'b1; wt(H);
      scl = 1'b0; wt(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; wt(H);
    scl = 1'b1; wt(H/2);
    ack = ~sda_line; wt(H/2);
    scl = 1'b0; wt(2);
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wt(H);
      scl = 1'b1; wt(H/2);
      b = {b[6:0], sda_line}; wt(H/2);
      scl = 1'b0; wt(2);
    end
    m_sda = nack; wt(H);
    scl = 1'b1; wt(H);
    scl = 1'b0; wt(2);
    m_sda = 1'b1;
  endtask

  // write transfer: address, instruction, n data bytes from dd (MSB byte first)
  task automatic wr(input logic [6:0] a, input logic [7:0] ins, input int n,
                    input logic [31:0] dd, input logic stop);
    logic ack, hit;
    hit = (a == own_addr(pins));
    bus_start();
    send_byte({a, 1'b0}, ack);
    chk("R2", "address ack", ack, hit);
    send_byte(ins, ack);
    chk("R3", "instruction ack", ack, hit);
    if (hit) begin
      m_sel = ins[7];
      m_shdn = ins[6];
    end
    for (int i = 0; i < n; i++) begin
      send_byte(dd[31-8*i -: 8], ack);
      chk("R4", "data ack", ack, hit);
      if (hit) m_reg[m_sel] = dd[31-8*i -: 8];
    end
    if (stop) bus_stop();
  endtask

  task automatic rd(input int n, input string req);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte({own_addr(pins), 1'b1}, ack);
    chk("R2", "read address ack", ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      read_byte(i == n - 1, b);
      chk(req, "read data", b, m_reg[m_sel]);
    end
    chk("R8", "released after nack", sda_pull, 1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_reg[0] = 8'h80;
    m_reg[1] = 8'h80;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    // R1 reset state
    chk_outs("R1");
    rd(1, "R1");

    // R2 wrong address: the shutdown instruction and data must be ignored
    wr(own_addr(pins) ^ 7'h40, 8'h40, 1, 32'h1200_0000, 1'b1);
    chk_outs("R2");

    // R3 don't-care bits set, R4 single write to channel 1
    wr(own_addr(pins), 8'h2A, 1, 32'h3C00_0000, 1'b1);
    chk_outs("R3");

    // R4 streaming write to channel 2, last byte wins
    pins = 2'b10;
    wr(own_addr(pins), 8'h80, 3, 32'h1122_3300, 1'b1);
    chk_outs("R4");

    // R6 repeated read of channel 2, R8 nack at end
    rd(3, "R6");
    chk_outs("R8");

    // R7 instruction-only write moves readback to channel 1
    wr(own_addr(pins), 8'h00, 0, 32'h0, 1'b1);
    rd(2, "R7");

    // R5 write during shutdown, then clear with instruction only
    wr(own_addr(pins), 8'h40, 1, 32'h9900_0000, 1'b1);
    chk_outs("R5");
    rd(1, "R5");
    wr(own_addr(pins), 8'h80, 0, 32'h0, 1'b1);
    chk_outs("R5");

    // R9 abort part-way through an address byte
    bus_start();
    send_bits(8'hFF, 3);
    wr(own_addr(pins), 8'h80, 1, 32'h6600_0000, 1'b1);
    chk_outs("R9");

    // R9 repeated start after the instruction, then new transfer
    wr(own_addr(pins), 8'h80, 0, 32'h0, 1'b0);
    wr(own_addr(pins), 8'h00, 1, 32'h5500_0000, 1'b1);
    chk_outs("R9");
    rd(1, "R9");

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [6:0] a;
      logic [7:0] ins;
      int n;
      pins = 2'($urandom % 4);
      a = own_addr(pins);
      if ($urandom % 4 == 0) a = a ^ 7'(1 << ($urandom % 7));
      ins = 8'($urandom);
      n = int'($urandom % 4);
      wr(a, ins, n, $urandom, 1'b1);
      chk_outs("R4");
      if ($urandom % 2 == 0) rd(1 + int'($urandom % 3), "R6");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule